// File: doc/BRIEF.md
# Dual-Clock FIFO with Even, Non-Power-of-Two Depth

This block moves data words from a write clock domain to an unrelated read clock domain. Either clock may be the faster one. The storage depth may be any even number of entries, for example 688, and need not be a power of two. Each domain keeps its own binary position counter. Every counter steps through a window of codes centred in the 2^N code space, where N = ceil(log2(DEPTH)). At the wrap, the Gray forms of the highest and lowest window values differ only in the top bit, so every step changes exactly one Gray bit.

Each domain passes only its registered Gray pointer to the other side, through a two-flop synchronizer. All flag comparisons are made on Gray codes, and no Gray-to-binary conversion is needed. Look-ahead copies of each pointer, one and two steps ahead, let `full`, `empty` and `almost_empty` be registered and still be correct on the edge that accepts an operation. Read data is registered, as block RAM provides it. One slot of the window is kept free to tell full from empty, so the FIFO holds at most DEPTH-1 words.

Top module: `gwf_fifo`

## Requirements
- R1: Words are delivered in write order and unaltered. `rd_data` carries the word of an accepted read after the next rising `rd_clk` edge.
- R2: Synchronous active-high reset. After reset, `empty`=1, `almost_empty`=1 and `full`=0.
- R3: Each pointer stays within [2^N/2-DEPTH/2, 2^N/2+DEPTH/2-1] and wraps from the top of that range to the bottom. Its Gray code (g = b XOR (b>>1)) changes in exactly one bit on each accepted operation, including the wrap, and holds otherwise. Streams many times longer than the depth pass intact.
- R4: `full` rises on the write edge that accepts the (DEPTH-1)th unread word, and stays low before that edge.
- R5: A write presented while `full`=1 is ignored. The pointer holds, and no extra word is ever read out.
- R6: `empty` rises on the read edge that accepts the last visible word. A read presented while `empty`=1 is ignored. After a write, `empty` falls within 8 `rd_clk` cycles.
- R7: `almost_empty` is 1 while the read side sees zero or one word, and 0 once it sees two or more. It is never 0 while `empty` is 1.
- R8: After a read frees a slot in a full FIFO, `full` falls within 8 `wr_clk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst | input | 1 | Write domain synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| full | output | 1 | No free slot; writes are ignored |
| rd_clk | input | 1 | Read domain clock |
| rd_rst | input | 1 | Read domain synchronous reset, active high |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Word of the last accepted read |
| empty | output | 1 | Nothing to read; reads are ignored |
| almost_empty | output | 1 | At most one word visible to the read side |

## Verification
The bench uses a 10-entry instance, whose window runs 3 to 12. It first pushes a single word and reads it back, which separates the 0-word and 1-word flag states. Reads issued on an empty FIFO are followed by a fresh word, so a pointer that moved would show up as a wrong or missing item. A fill to capacity followed by extra writes pins the exact edge where `full` rises, and shows that the rejected words never appear. A long stream of 60 words with irregular gaps on both sides crosses the window wrap six times, which exposes any wrap value or Gray step that breaks ordering.

// File: rtl/gwf_pkg.sv
package gwf_pkg;
  // Pointer width for a given depth
  function automatic int unsigned gwf_ptr_w(input int unsigned depth);
    return $clog2(depth);
  endfunction

  // Lower bound of the centred counting window
  function automatic int unsigned gwf_lo(input int unsigned depth);
    return ((1 << $clog2(depth)) / 2) - depth / 2;
  endfunction

  // Upper bound of the centred counting window
  function automatic int unsigned gwf_hi(input int unsigned depth);
    return ((1 << $clog2(depth)) / 2) + depth / 2 - 1;
  endfunction
endpackage

// File: rtl/gwf_sync.sv
module gwf_sync #(
  parameter int unsigned     W     = 10,
  parameter logic [W-1:0]    RST_V = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_V;
      q      <= RST_V;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gwf_ptr.sv
module gwf_ptr #(
  parameter int unsigned W  = 10,
  parameter int unsigned LO = 168,
  parameter int unsigned HI = 855
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] bin,
  output logic [W-1:0] gray,
  output logic [W-1:0] gray_nxt,
  output logic [W-1:0] gray_nxt2
);
  localparam logic [W-1:0] LO_V = W'(LO);
  localparam logic [W-1:0] HI_V = W'(HI);
  localparam logic [W-1:0] LO1  = W'(LO + 1);
  localparam logic [W-1:0] LO2  = W'(LO + 2);

  function automatic logic [W-1:0] to_gray(input logic [W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [W-1:0] p1, p2, p2_step;

  // Window step: the top value wraps to the bottom value
  assign p2_step = (p2 == HI_V) ? LO_V : p2 + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      bin       <= LO_V;
      p1        <= LO1;
      p2        <= LO2;
      gray      <= to_gray(LO_V);
      gray_nxt  <= to_gray(LO1);
      gray_nxt2 <= to_gray(LO2);
    end else if (adv) begin
      bin       <= p1;
      p1        <= p2;
      p2        <= p2_step;
      gray      <= gray_nxt;
      gray_nxt  <= gray_nxt2;
      gray_nxt2 <= to_gray(p2_step);
    end
  end
endmodule

// File: rtl/gwf_ram.sv
module gwf_ram #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 688,
  parameter int unsigned AW    = 10
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/gwf_fifo.sv
module gwf_fifo
  import gwf_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 688
) (
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          almost_empty
);
  localparam int unsigned PW = gwf_ptr_w(DEPTH);
  localparam int unsigned LO = gwf_lo(DEPTH);
  localparam int unsigned HI = gwf_hi(DEPTH);
  localparam logic [PW-1:0] LO_V   = PW'(LO);
  localparam logic [PW-1:0] G_RST  = LO_V ^ (LO_V >> 1);

  logic          wr_acc, rd_acc;
  logic [PW-1:0] wr_b, wr_g, wr_gn, wr_gn2;
  logic [PW-1:0] rd_b, rd_g, rd_gn, rd_gn2;
  logic [PW-1:0] rq2, wq2;

  assign wr_acc = wr_en & ~full;
  assign rd_acc = rd_en & ~empty;

  gwf_ptr #(.W(PW), .LO(LO), .HI(HI)) u_wptr (
    .clk(wr_clk), .rst(wr_rst), .adv(wr_acc),
    .bin(wr_b), .gray(wr_g), .gray_nxt(wr_gn), .gray_nxt2(wr_gn2)
  );

  gwf_ptr #(.W(PW), .LO(LO), .HI(HI)) u_rptr (
    .clk(rd_clk), .rst(rd_rst), .adv(rd_acc),
    .bin(rd_b), .gray(rd_g), .gray_nxt(rd_gn), .gray_nxt2(rd_gn2)
  );

  // Read Gray pointer into the write domain
  gwf_sync #(.W(PW), .RST_V(G_RST)) u_rsync (
    .clk(wr_clk), .rst(wr_rst), .d(rd_g), .q(rq2)
  );

  // Write Gray pointer into the read domain
  gwf_sync #(.W(PW), .RST_V(G_RST)) u_wsync (
    .clk(rd_clk), .rst(rd_rst), .d(wr_g), .q(wq2)
  );

  gwf_ram #(.DW(DW), .DEPTH(DEPTH), .AW(PW)) u_ram (
    .wclk(wr_clk), .we(wr_acc), .waddr(wr_b - LO_V), .wdata(wr_data),
    .rclk(rd_clk), .re(rd_acc), .raddr(rd_b - LO_V), .rdata(rd_data)
  );

  // Full: the slot after the write pointer is the read pointer.
  // Look-ahead by one more step when this edge accepts a write.
  always_ff @(posedge wr_clk) begin
    if (wr_rst) full <= 1'b0;
    else        full <= wr_acc ? (wr_gn2 == rq2) : (wr_gn == rq2);
  end

  // Empty / almost-empty from the read pointer and its look-ahead copies
  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      empty        <= 1'b1;
      almost_empty <= 1'b1;
    end else if (rd_acc) begin
      empty        <= (rd_gn == wq2);
      almost_empty <= (rd_gn == wq2) || (rd_gn2 == wq2);
    end else begin
      empty        <= (rd_g == wq2);
      almost_empty <= (rd_g == wq2) || (rd_gn == wq2);
    end
  end
endmodule

// File: rtl/gwf_fifo_chk.sv
module gwf_fifo_chk #(
  parameter int unsigned W  = 10,
  parameter int unsigned LO = 168,
  parameter int unsigned HI = 855
) (
  input logic         wr_clk,
  input logic         wr_rst,
  input logic         wr_en,
  input logic         full,
  input logic [W-1:0] wr_g,
  input logic [W-1:0] wr_b,
  input logic         rd_clk,
  input logic         rd_rst,
  input logic         rd_en,
  input logic         empty,
  input logic         almost_empty,
  input logic [W-1:0] rd_g,
  input logic [W-1:0] rd_b
);
  localparam logic [W-1:0] LO_V = W'(LO);
  localparam logic [W-1:0] HI_V = W'(HI);

  a_r2_reset_full: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $past(wr_rst) |-> !full);

  a_r2_reset_empty: assert property (@(posedge rd_clk) disable iff (rd_rst)
    $past(rd_rst) |-> (empty && almost_empty));

  a_r3_wr_one_bit: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_en && !full) |=> ($countones(wr_g ^ $past(wr_g)) == 1));

  a_r3_rd_one_bit: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_en && !empty) |=> ($countones(rd_g ^ $past(rd_g)) == 1));

  a_r3_wr_window: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_b >= LO_V) && (wr_b <= HI_V));

  a_r3_rd_window: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_b >= LO_V) && (rd_b <= HI_V));

  a_r5_full_write_ignored: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_en && full) |=> ($stable(wr_g) && $stable(wr_b)));

  a_r6_empty_read_ignored: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_en && empty) |=> ($stable(rd_g) && $stable(rd_b)));

  a_r7_empty_implies_low_mark: assert property (@(posedge rd_clk) disable iff (rd_rst)
    empty |-> almost_empty);
endmodule

bind gwf_fifo gwf_fifo_chk #(.W(PW), .LO(LO), .HI(HI)) u_chk (
  .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .full(full),
  .wr_g(wr_g), .wr_b(wr_b),
  .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .empty(empty),
  .almost_empty(almost_empty), .rd_g(rd_g), .rd_b(rd_b)
);

// File: tb/gwf_fifo_tb.sv
module gwf_fifo_tb;
  localparam int DW    = 8;
  localparam int DEPTH = 10;
  localparam int NSTREAM = 60;

  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          wr_rst = 1'b1, rd_rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          full, empty, almost_empty;

  gwf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_data(rd_data),
    .empty(empty), .almost_empty(almost_empty)
  );

  always #5 wr_clk = ~wr_clk;   // 100 MHz write clock
  always #7 rd_clk = ~rd_clk;   // unrelated read clock

  int n_chk = 0, n_bad = 0, n_rd = 0;
  bit pend = 1'b0, done = 1'b0;
  logic [DW-1:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: one write attempt, scoreboard gets the word if accepted
  task automatic push(input logic [DW-1:0] d, output bit acc);
    @(posedge wr_clk); #1;
    wr_en = 1'b1; wr_data = d;
    @(negedge wr_clk);
    acc = !full;
    if (acc) exp_q.push_back(d);
    @(posedge wr_clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic pull(output bit acc);
    @(posedge rd_clk); #1;
    rd_en = 1'b1;
    @(negedge rd_clk);
    acc = !empty;
    @(posedge rd_clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic wait_rd(input int n);
    repeat (n) @(negedge rd_clk);
  endtask

  // Monitor: compare the word of each accepted read (R1)
  always @(negedge rd_clk) begin
    if (pend) begin
      n_rd++;
      if (exp_q.size() == 0) chk(1'b0, "R1", "unexpected word", int'(rd_data), -1);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R1", "rd_data", int'(rd_data), int'(e));
      end
    end
    pend = rd_en && !empty;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    bit acc;
    int base;
    #41;
    wr_rst = 1'b0;
    rd_rst = 1'b0;
    wait_rd(1);
    // R2 reset state
    chk(empty == 1'b1,        "R2", "empty", empty, 1);
    chk(almost_empty == 1'b1, "R2", "almost_empty", almost_empty, 1);
    chk(full == 1'b0,         "R2", "full", full, 0);

    // Single word: R6 release, R7 one-word state, R6 re-assert
    push(8'h11, acc);
    wait_rd(8);
    chk(empty == 1'b0,        "R6", "empty after write", empty, 0);
    chk(almost_empty == 1'b1, "R7", "almost_empty at one word", almost_empty, 1);
    pull(acc);
    chk(acc, "R6", "read accepted", acc, 1);
    @(negedge rd_clk);
    chk(empty == 1'b1, "R6", "empty after last read", empty, 1);

    // R6: reads while empty are ignored
    for (int i = 0; i < 3; i++) begin
      pull(acc);
      chk(!acc, "R6", "read on empty accepted", acc, 0);
    end
    push(8'h22, acc);
    wait_rd(8);
    pull(acc);
    wait_rd(2);
    chk(exp_q.size() == 0 && empty, "R6", "queue/empty after 0x22", exp_q.size(), 0);

    // R4 fill to capacity DEPTH-1, R7 two-word state
    for (int i = 0; i < DEPTH - 2; i++) push(DW'(8'h30 + i), acc);
    @(negedge wr_clk);
    chk(full == 1'b0, "R4", "full before last slot", full, 0);
    wait_rd(8);
    chk(almost_empty == 1'b0, "R7", "almost_empty with many words", almost_empty, 0);
    push(8'h3F, acc);
    @(negedge wr_clk);
    chk(full == 1'b1, "R4", "full at capacity", full, 1);

    // R5 writes while full
    push(8'hEE, acc);
    chk(!acc, "R5", "write on full accepted", acc, 0);
    push(8'hEF, acc);
    chk(!acc && full, "R5", "full held", full, 1);

    // R8 release of full after one read
    pull(acc);
    base = 0;
    while (full && base < 8) begin
      @(negedge wr_clk);
      base++;
    end
    chk(full == 1'b0, "R8", "full after read", full, 0);

    for (int i = 0; i < DEPTH - 2; i++) pull(acc);
    wait_rd(2);
    chk(empty == 1'b1, "R5", "empty after drain", empty, 1);
    chk(exp_q.size() == 0, "R5", "leftover words", exp_q.size(), 0);

    // R3: long stream across many window wraps, irregular gaps
    base = n_rd;
    fork
      begin
        for (int i = 0; i < NSTREAM; i++) begin
          bit a;
          if (i % 4 == 3) repeat (2) @(posedge wr_clk);
          do push(DW'(i * 7 + 3), a); while (!a);
        end
      end
      begin
        int got = 0;
        while (got < NSTREAM) begin
          bit a;
          pull(a);
          if (a) begin
            got++;
            if (got % 5 == 2) repeat (3) @(posedge rd_clk);
          end
        end
      end
    join
    wait_rd(3);
    chk(n_rd - base == NSTREAM, "R3", "words through wraps", n_rd - base, NSTREAM);
    chk(exp_q.size() == 0 && empty, "R3", "leftover after stream", exp_q.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule